// File: doc/BRIEF.md
# Derivative-Product Maximum Power Point Tracker

This block steers a boost converter's duty cycle toward the peak of a solar panel's power curve. It works entirely in fixed point. Each accepted sample of panel voltage and current gives a power value. The block differences power and current against the previous accepted sample and smooths both differences with a first-order low-pass whose coefficient is programmable. It multiplies the two smoothed slopes to form a tracking error. A proportional-integral stage with a clamped, non-winding integrator turns that error into a duty command.

The surrounding system strobes in one voltage/current pair per control tick. The block returns a duty word and a one-cycle valid pulse a fixed four cycles later. The fixed latency lets the loop run far above audio-rate control ticks at ordinary clock rates. The gains, the low-pass coefficient, the duty limits and the reset value of the duty are all inputs. The converter settles wherever the product of the power and current slopes averages to zero.

Top module: `mppt_dprod`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `duty_out` equals `duty_init`. The integrator starts at `duty_init`, and the stored previous power, previous current and both filter states start at zero. A reset in the middle of a calculation discards that calculation.
- R2: A sample accepted at a rising edge produces `out_valid` high for exactly one cycle, in the fourth cycle after the strobe cycle.
- R3: `in_valid` is accepted only when no sample is in flight. Strobes in the three cycles after an accepted strobe are ignored, including their voltage and current values. A strobe in the cycle where `out_valid` is high is accepted.
- R4: Voltage and current are signed Q4.12. Power is the product of voltage and current, rounded half-up to signed Q8.16. Current is moved to Q8.16 by a left shift of 4. Each raw slope is the new value minus the previous accepted value, saturated to 24 bits.
- R5: Each filter state `y` updates as `y + round(alpha*(d - y))`, where `d` is the slope and `alpha` is unsigned Q0.16, with the result saturated. With `alpha` = 0 the error stays zero and `duty_out` stays at `duty_init`.
- R6: The error is the product of the two filtered slopes, rounded half-up to Q8.16 and saturated to the signed 24-bit range (-8388608..8388607).
- R7: `kp` and `ki` are unsigned Q4.12. Each gain-times-error product is rounded to Q8.16 and saturated. The integrator adds the `ki` term. The output is the updated integrator plus the `kp` term.
- R8: The integrator and the output are both clamped to [`duty_min`, `duty_max`]. While the integrator is held at a limit it does not accumulate beyond it, so a reversal of the error sign moves the duty off the limit on the very next result.
- R9: When the error product overflows, it saturates instead of wrapping. With v=-32768, i=32767, alpha=65535, kp=1, ki=0 and `duty_init`=30000 from reset, the first result is 27952.
- R10: `duty_out` changes only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| v_in | input | 16 | Panel voltage, signed Q4.12 |
| i_in | input | 16 | Panel current, signed Q4.12 |
| alpha | input | 16 | Low-pass coefficient, unsigned Q0.16 |
| kp | input | 16 | Proportional gain, unsigned Q4.12 |
| ki | input | 16 | Integral gain, unsigned Q4.12 |
| duty_min | input | 16 | Lower duty limit, unsigned Q0.16 |
| duty_max | input | 16 | Upper duty limit, unsigned Q0.16 |
| duty_init | input | 16 | Duty and integrator value after reset |
| out_valid | output | 1 | One-cycle result strobe |
| duty_out | output | 16 | Duty command, unsigned Q0.16 |

## Verification
Two things can happen in the same cycle: the result of one sample is delivered, and the next strobe is accepted. The bench holds `in_valid` high through the three busy cycles with unrelated values. It then presents a fresh sample in exactly the cycle where `out_valid` rises. It requires the first result to match a model that never saw the ignored values, and the second result to arrive four cycles later with the correct value. The other collision is between integrator clamping and a sign reversal of the error. A ramp drives the duty into `duty_max`, a falling-power sample follows, and the duty must leave the limit at once and land at the value the model predicts.

// File: rtl/mppt_dprod.sv
`timescale 1ns/1ps
module mppt_dprod #(
  parameter int IW    = 16,
  parameter int IFRAC = 12,
  parameter int AW    = 24,
  parameter int AFRAC = 16,
  parameter int CW    = 16,
  parameter int KW    = 16,
  parameter int KFRAC = 12,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] v_in,
  input  logic signed [IW-1:0] i_in,
  input  logic [CW-1:0]        alpha,
  input  logic [KW-1:0]        kp,
  input  logic [KW-1:0]        ki,
  input  logic [DW-1:0]        duty_min,
  input  logic [DW-1:0]        duty_max,
  input  logic [DW-1:0]        duty_init,
  output logic                 out_valid,
  output logic [DW-1:0]        duty_out
);
  localparam int PSH = 2*IFRAC - AFRAC;
  localparam int ISH = AFRAC - IFRAC;
  localparam logic signed [63:0] AMAX = (64'sd1 <<< (AW-1)) - 64'sd1;
  localparam logic signed [63:0] AMIN = -(64'sd1 <<< (AW-1));

  function automatic logic signed [AW-1:0] rsat(input logic signed [63:0] x, input int sh);
    logic signed [63:0] t;
    if (sh > 0) t = (x + (64'sd1 <<< (sh-1))) >>> sh;
    else        t = x;
    if (t > AMAX)      t = AMAX;
    else if (t < AMIN) t = AMIN;
    return t[AW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] clampd(input logic signed [63:0] x,
                                                  input logic signed [63:0] lo,
                                                  input logic signed [63:0] hi);
    logic signed [63:0] t;
    if (x > hi)      t = hi;
    else if (x < lo) t = lo;
    else             t = x;
    return t[AW-1:0];
  endfunction

  logic v1, v2, v3, ov;
  logic signed [AW-1:0] p1, i1, pp, ip, yp, yi, err, integ;
  logic [DW-1:0] duty_q;

  logic acc;
  assign acc = in_valid & ~(v1 | v2 | v3);

  logic signed [63:0] m_vi, lo, hi;
  assign m_vi = 64'(v_in) * 64'(i_in);
  assign lo   = $signed(64'(duty_min));
  assign hi   = $signed(64'(duty_max));

  logic signed [AW-1:0] dp, di, sp, si, yp_n, yi_n, e_n, kie, kpe, ig_n, u_n;
  assign dp   = rsat(64'(p1) - 64'(pp), 0);
  assign di   = rsat(64'(i1) - 64'(ip), 0);
  assign sp   = rsat($signed(64'(alpha)) * (64'(dp) - 64'(yp)), CW);
  assign si   = rsat($signed(64'(alpha)) * (64'(di) - 64'(yi)), CW);
  assign yp_n = rsat(64'(yp) + 64'(sp), 0);
  assign yi_n = rsat(64'(yi) + 64'(si), 0);
  assign e_n  = rsat(64'(yp) * 64'(yi), AFRAC);
  assign kie  = rsat($signed(64'(ki)) * 64'(err), KFRAC);
  assign kpe  = rsat($signed(64'(kp)) * 64'(err), KFRAC);
  assign ig_n = clampd(64'(integ) + 64'(kie), lo, hi);
  assign u_n  = clampd(64'(ig_n) + 64'(kpe), lo, hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      {v1, v2, v3, ov} <= '0;
      p1 <= '0; i1 <= '0; pp <= '0; ip <= '0;
      yp <= '0; yi <= '0; err <= '0;
      integ  <= $signed(AW'(duty_init));
      duty_q <= duty_init;
    end else begin
      v1 <= acc; v2 <= v1; v3 <= v2; ov <= v3;
      if (acc) begin
        p1 <= rsat(m_vi, PSH);
        i1 <= rsat(64'(i_in) <<< ISH, 0);
      end
      if (v1) begin
        pp <= p1; ip <= i1;
        yp <= yp_n; yi <= yi_n;
      end
      if (v2) err <= e_n;
      if (v3) begin
        integ  <= ig_n;
        duty_q <= DW'(u_n);
      end
    end
  end

  assign out_valid = ov;
  assign duty_out  = duty_q;

  a_r2_latency: assert property (@(posedge clk) disable iff (rst) acc |-> ##4 out_valid);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  a_r3_strobe_origin: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid, 4));
  a_r8_in_limits: assert property (@(posedge clk) disable iff (rst)
    (out_valid && duty_min <= duty_max) |-> (duty_out >= duty_min && duty_out <= duty_max));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst) !$stable(duty_out) |-> out_valid);
endmodule

// File: tb/test_mppt_dprod.sv
`timescale 1ns/1ps
module test_mppt_dprod;
  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [15:0] v_in = 0, i_in = 0;
  logic [15:0] alpha = 0, kp = 0, ki = 0, duty_min = 0, duty_max = 16'hFFFF, duty_init = 0;
  logic out_valid;
  logic [15:0] duty_out;

  always #5 clk = ~clk;

  mppt_dprod i_mppt_dprod (.clk(clk), .rst(rst), .in_valid(in_valid), .v_in(v_in), .i_in(i_in),
    .alpha(alpha), .kp(kp), .ki(ki), .duty_min(duty_min), .duty_max(duty_max),
    .duty_init(duty_init), .out_valid(out_valid), .duty_out(duty_out));

  localparam int NV = 8;
  localparam logic signed [15:0] TV [NV] = '{16'sd4096, 16'sd4096, 16'sd4096, 16'sd4096,
                                              16'sd4096, 16'sd2048, 16'sd1024, 16'sd1024};
  localparam logic signed [15:0] TI [NV] = '{16'sd1024, 16'sd2048, 16'sd3072, 16'sd4096,
                                              16'sd5120, 16'sd6144, 16'sd7168, 16'sd1024};

  int n_cmp = 0, n_bad = 0;
  longint m_pp, m_ip, m_yp, m_yi, m_ig, m_duty;

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint rs(longint x, int sh);
    longint t;
    t = (sh > 0) ? ((x + (longint'(1) <<< (sh-1))) >>> sh) : x;
    if (t > 8388607) t = 8388607;
    if (t < -8388608) t = -8388608;
    return t;
  endfunction

  function automatic longint clip(longint x);
    if (x > longint'(duty_max)) return longint'(duty_max);
    if (x < longint'(duty_min)) return longint'(duty_min);
    return x;
  endfunction

  task automatic model(logic signed [15:0] v, logic signed [15:0] i);
    longint p, ia, dp, di, e, kie, kpe;
    p  = rs(longint'(v) * longint'(i), 8);
    ia = longint'(i) * 16;
    dp = rs(p - m_pp, 0);
    di = rs(ia - m_ip, 0);
    m_pp = p; m_ip = ia;
    m_yp = rs(m_yp + rs(longint'(alpha) * (dp - m_yp), 16), 0);
    m_yi = rs(m_yi + rs(longint'(alpha) * (di - m_yi), 16), 0);
    e   = rs(m_yp * m_yi, 16);
    kie = rs(longint'(ki) * e, 12);
    kpe = rs(longint'(kp) * e, 12);
    m_ig   = clip(m_ig + kie);
    m_duty = clip(m_ig + kpe);
  endtask

  task automatic do_reset(logic [15:0] a, logic [15:0] p, logic [15:0] k,
                          logic [15:0] lo, logic [15:0] hi, logic [15:0] ini);
    @(negedge clk);
    rst = 1; in_valid = 0;
    alpha = a; kp = p; ki = k; duty_min = lo; duty_max = hi; duty_init = ini;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 duty in reset", duty_out, ini);
    rst = 0;
    m_pp = 0; m_ip = 0; m_yp = 0; m_yi = 0; m_ig = ini; m_duty = ini;
    @(negedge clk);
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 duty after reset", duty_out, ini);
  endtask

  task automatic send(logic signed [15:0] v, logic signed [15:0] i, string req);
    @(negedge clk);
    in_valid = 1; v_in = v; i_in = i;
    @(negedge clk);
    in_valid = 0;
    model(v, i);
    repeat (2) @(negedge clk);
    chk("R2 no early valid", out_valid, 0);
    @(negedge clk);
    chk("R2 valid at 4", out_valid, 1);
    chk(req, duty_out, m_duty);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset(16'd65535, 16'd2048, 16'd16384, 16'd8000, 16'd60000, 16'd30000);
    for (int k = 0; k < NV; k++) begin
      send(TV[k], TI[k], "R4 R6 R7 table duty");
      if (k == 4) chk("R8 clamped at max", duty_out, 60000);
      if (k == 5) chk("R8 leaves max at once", duty_out < 60000, 1);
      if (k == 6) chk("R8 clamped at min", duty_out, 8000);
      @(negedge clk);
      chk("R10 duty held", duty_out, m_duty);
      chk("R2 pulse one cycle", out_valid, 0);
    end

    do_reset(16'd65535, 16'd2048, 16'd16384, 16'd8000, 16'd60000, 16'd30000);
    @(negedge clk);
    in_valid = 1; v_in = 16'sd4096; i_in = 16'sd1024;
    model(16'sd4096, 16'sd1024);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      v_in = 16'sd100; i_in = -16'sd5000;
    end
    @(negedge clk);
    chk("R3 result of first", out_valid, 1);
    chk("R3 busy strobes ignored", duty_out, m_duty);
    v_in = 16'sd4096; i_in = 16'sd2048;
    model(16'sd4096, 16'sd2048);
    @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);
    chk("R3 no early valid", out_valid, 0);
    @(negedge clk);
    chk("R3 strobe at valid accepted", out_valid, 1);
    chk("R3 second duty", duty_out, m_duty);

    do_reset(16'd0, 16'd2048, 16'd16384, 16'd0, 16'd65535, 16'd30000);
    for (int k = 0; k < 3; k++) begin
      send(TV[k], TI[k], "R5 alpha zero model");
      chk("R5 alpha zero holds", duty_out, 30000);
    end

    do_reset(16'd32768, 16'd2048, 16'd16384, 16'd0, 16'd65535, 16'd30000);
    for (int k = 0; k < 5; k++) send(TV[k], TI[k], "R5 alpha half");

    do_reset(16'd65535, 16'd1, 16'd0, 16'd0, 16'd65535, 16'd30000);
    send(-16'sd32768, 16'sd32767, "R9 saturated model");
    chk("R9 saturated error", duty_out, 27952);
    send(-16'sd32768, -16'sd32768, "R6 R9 second sample");

    do_reset(16'd65535, 16'd2048, 16'd16384, 16'd0, 16'd65535, 16'd12345);
    @(negedge clk);
    in_valid = 1; v_in = 16'sd4096; i_in = 16'sd4096;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    repeat (4) begin
      @(negedge clk);
      chk("R1 flight dropped", out_valid, 0);
    end
    chk("R1 duty after mid reset", duty_out, 12345);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule